// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of one burst into a row of a synchronous DRAM-style memory. A start strobe loads a start column, a burst length code and an order bit. From the next cycle on, the block presents one column address per beat. It moves to the following beat on every cycle in which the advance enable is high, and it holds the current address otherwise.

Two beat orders are supported. Wrapping sequential order counts up inside an aligned window of the burst length. Interleaved order XORs the beat index into the low address bits. A full-page length runs through the whole row and wraps at the row end. It never finishes by itself and ends only on a stop request or a new start.

A last-beat flag marks the final address of every fixed-length burst. A stop input ends any burst at once, and a new start during a burst restarts from the new column. Command issue, data transfer and memory timing are handled by the surrounding controller.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `col_vld`, `last` and `col_out` are all 0.
- R2: In the cycle after a clock edge with `start` high, `col_vld` is 1 and `col_out` equals the `start_col` sampled at that edge. `bl_code` and `itl` are sampled only at that edge.
- R3: While a burst is active, a clock edge with `adv` low and no `start` or `stop` leaves `col_out` and `col_vld` unchanged. A clock edge with `adv` high moves the burst to the next beat.
- R4: With `itl` = 0 and a fixed length L, beat k shows the start column with its low log2(L) bits replaced by (start + k) mod L. The upper bits stay at their start values.
- R5: With `itl` = 1 and a fixed length L, beat k shows the start column with its low log2(L) bits XORed with k. The upper bits stay at their start values.
- R6: `bl_code` selects the length as follows: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. The unused codes 3'b100, 3'b101 and 3'b110 behave as length 1.
- R7: `last` is high exactly while the final beat of a fixed-length burst is shown. An `adv` edge on that beat ends the burst, so `col_vld` is 0 in the next cycle.
- R8: In full-page mode, beat k shows (start + k) mod 2^COL_W, wrapping from the top column to 0. `last` stays 0, the burst runs until a stop or a new start, and `itl` is ignored.
- R9: A clock edge with `stop` high and `start` low ends the burst, so `col_vld` is 0 in the next cycle. `stop` takes priority over `adv`.
- R10: A `start` during an active burst restarts the sequence at beat 0 with the new column, length and order. `start` takes priority over `stop`.
- R11: While no burst is active, `adv` and `stop` have no effect, and `col_vld` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin (or restart) a burst |
| start_col | input | COL_W | First column of the burst |
| bl_code | input | 3 | Burst length code, sampled on start |
| itl | input | 1 | Order: 0 sequential, 1 interleaved; sampled on start |
| adv | input | 1 | Move to the next beat |
| stop | input | 1 | End the burst now |
| col_out | output | COL_W | Column address of the current beat |
| col_vld | output | 1 | A burst beat is being shown |
| last | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
Directed bursts cover each length and each order. Start columns sit in the middle of a window, so a sequential burst that wraps inside its window can be told apart from one that carries into the upper bits. It can also be told apart from an interleaved burst, which reaches the same set of addresses in a different order.

A full-page burst that starts just below the row end shows whether the count wraps to 0 and whether the order bit is wrongly honoured. Collisions such as stop with advance, start with stop, and start in the middle of a burst check the priority rules.

Random bursts with random advance gaps, random stops and random restarts are then compared beat by beat against a bench model of the address formula.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   localparam logic [2:0] BL_ONE   = 3'b000;
   localparam logic [2:0] BL_TWO   = 3'b001;
   localparam logic [2:0] BL_FOUR  = 3'b010;
   localparam logic [2:0] BL_EIGHT = 3'b011;
   localparam logic [2:0] BL_PAGE  = 3'b111;

   // log2 of the fixed burst length; unused codes map to a single beat
   function automatic int unsigned len_log2(input logic [2:0] code);
      case (code)
         BL_TWO:   return 1;
         BL_FOUR:  return 2;
         BL_EIGHT: return 3;
         default:  return 0;
      endcase
   endfunction

   function automatic logic is_page(input logic [2:0] code);
      return code == BL_PAGE;
   endfunction
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode #(
   parameter int unsigned COL_W = 9
) (
   input  logic [2:0]       code,
   output logic [COL_W-1:0] mask,
   output logic             full
);
   import bcs_pkg::*;

   localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

   always_comb begin
      full = is_page(code);
      if (full) mask = '1;
      else      mask = (ONE << len_log2(code)) - ONE;
   end
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl #(
   parameter int unsigned COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             adv,
   input  logic [COL_W-1:0] mask_q,
   input  logic             full_q,
   output logic             active,
   output logic [COL_W-1:0] beat,
   output logic             last
);
   logic at_end;

   // the beat index reaching the window mask means the final beat
   assign at_end = !full_q && (beat == mask_q);
   assign last   = active && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         beat   <= '0;
      end else if (start) begin
         active <= 1'b1;
         beat   <= '0;
      end else if (stop) begin
         active <= 1'b0;
      end else if (adv && active) begin
         if (at_end) active <= 1'b0;
         else        beat   <= beat + 1'b1;
      end
   end
endmodule

// File: rtl/bcs_addr_map.sv
module bcs_addr_map #(
   parameter int unsigned COL_W  = 9,
   parameter bit          ITL_EN = 1'b1
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] beat,
   input  logic [COL_W-1:0] mask,
   input  logic             itl,
   output logic [COL_W-1:0] addr
);
   logic [COL_W-1:0] fixed_part;
   logic [COL_W-1:0] seq_part;

   assign fixed_part = base & ~mask;
   assign seq_part   = (base + beat) & mask;

   generate
      if (ITL_EN) begin : g_both_orders
         logic [COL_W-1:0] xor_part;
         assign xor_part = (base ^ beat) & mask;
         assign addr     = fixed_part | (itl ? xor_part : seq_part);
      end else begin : g_seq_only
         logic unused_itl;
         assign unused_itl = itl;
         assign addr       = fixed_part | seq_part;
      end
   endgenerate
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
   parameter int unsigned COL_W  = 9,
   parameter bit          ITL_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       bl_code,
   input  logic             itl,
   input  logic             adv,
   input  logic             stop,
   output logic [COL_W-1:0] col_out,
   output logic             col_vld,
   output logic             last
);
   generate
      if (COL_W < 3) begin : g_bad_width
         $error("burst_col_seq: COL_W must cover an 8-beat window");
      end
   endgenerate

   logic [COL_W-1:0] mask_d, mask_q, base_q, beat;
   logic             full_d, full_q, itl_q, active;

   bcs_len_decode #(.COL_W(COL_W)) u_dec (
      .code (bl_code),
      .mask (mask_d),
      .full (full_d)
   );

   // burst settings are captured only on start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         full_q <= 1'b0;
         itl_q  <= 1'b0;
      end else if (start) begin
         base_q <= start_col;
         mask_q <= mask_d;
         full_q <= full_d;
         itl_q  <= itl && !full_d;
      end
   end

   bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .stop   (stop),
      .adv    (adv),
      .mask_q (mask_q),
      .full_q (full_q),
      .active (active),
      .beat   (beat),
      .last   (last)
   );

   bcs_addr_map #(.COL_W(COL_W), .ITL_EN(ITL_EN)) u_map (
      .base (base_q),
      .beat (beat),
      .mask (mask_q),
      .itl  (itl_q),
      .addr (col_out)
   );

   assign col_vld = active;
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
   parameter int unsigned COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [COL_W-1:0] start_col,
   input logic [2:0]       bl_code,
   input logic             adv,
   input logic             stop,
   input logic [COL_W-1:0] col_out,
   input logic             col_vld,
   input logic             last
);
   logic [COL_W-1:0] win_c;
   logic             page_c;

   // own copy of the burst window, taken from the ports at start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_c  <= '0;
         page_c <= 1'b0;
      end else if (start) begin
         page_c <= (bl_code == 3'b111);
         case (bl_code)
            3'b001:  win_c <= COL_W'(1);
            3'b010:  win_c <= COL_W'(3);
            3'b011:  win_c <= COL_W'(7);
            3'b111:  win_c <= '1;
            default: win_c <= '0;
         endcase
      end
   end

   logic moving;
   assign moving = col_vld && adv && !last && !start && !stop;

   a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> col_vld && col_out == $past(start_col));
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      col_vld && !adv && !start && !stop |=> col_vld && $stable(col_out));
   // R4 and R5: bits above the window never move
   a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      moving && !page_c |=> (col_out & ~win_c) == ($past(col_out) & ~win_c));
   a_r4_low_bit_steps: assert property (@(posedge clk) disable iff (!rst_n)
      moving |=> col_out[0] != $past(col_out[0]));
   a_r7_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> col_vld);
   a_r7_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      last && adv && !start && !stop |=> !col_vld);
   a_r8_no_last_page: assert property (@(posedge clk) disable iff (!rst_n)
      page_c && col_vld |-> !last);
   a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
      stop && !start |=> !col_vld);
   a_r11_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
      !col_vld && !start |=> !col_vld);
endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .start_col (start_col),
   .bl_code   (bl_code),
   .adv       (adv),
   .stop      (stop),
   .col_out   (col_out),
   .col_vld   (col_vld),
   .last      (last)
);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
   localparam int COL_W = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0, itl = 1'b0, adv = 1'b0, stop = 1'b0;
   logic [COL_W-1:0] start_col = '0;
   logic [2:0]       bl_code = '0;
   logic [COL_W-1:0] col_out;
   logic             col_vld, last;

   int checks = 0, errors = 0;

   // model state
   logic             m_act = 1'b0;
   int unsigned      m_k = 0;
   logic [COL_W-1:0] m_base = '0;
   logic [2:0]       m_code = '0;
   logic             m_itl = 1'b0;

   always #2 clk = ~clk;

   burst_col_seq #(.COL_W(COL_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
      .bl_code(bl_code), .itl(itl), .adv(adv), .stop(stop),
      .col_out(col_out), .col_vld(col_vld), .last(last)
   );

   function automatic int unsigned blen(input logic [2:0] c);
      case (c)
         3'b001:  return 2;
         3'b010:  return 4;
         3'b011:  return 8;
         default: return 1;
      endcase
   endfunction

   function automatic logic [COL_W-1:0] exp_addr(input logic [COL_W-1:0] b,
      input logic [2:0] c, input logic it, input int unsigned k);
      logic [COL_W-1:0] kk, msk;
      kk = COL_W'(k);
      if (c == 3'b111) return b + kk;
      msk = COL_W'(blen(c) - 1);
      if (it) return (b & ~msk) | ((b ^ kk) & msk);
      return (b & ~msk) | ((b + kk) & msk);
   endfunction

   function automatic logic m_last();
      return m_act && m_code != 3'b111 && m_k == blen(m_code) - 1;
   endfunction

   task automatic chk(input string tg, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tg, act, exp);
      end
   endtask

   task automatic check_all(input string tg);
      string mt;
      chk(tg, int'(col_vld), int'(m_act));
      if (m_act) begin
         if (m_code == 3'b111) mt = "R8";
         else if (m_itl)       mt = "R5";
         else                  mt = "R4";
         chk(mt, int'(col_out), int'(exp_addr(m_base, m_code, m_itl, m_k)));
         chk("R7", int'(last), int'(m_last()));
      end else begin
         chk("R7", int'(last), 0);
      end
   endtask

   task automatic cyc(input logic s, input logic [COL_W-1:0] c, input logic [2:0] bc,
                      input logic it, input logic a, input logic sp, input string tg);
      start = s; start_col = c; bl_code = bc; itl = it; adv = a; stop = sp;
      @(posedge clk);
      if (s) begin
         m_act = 1'b1; m_k = 0; m_base = c; m_code = bc; m_itl = it;
      end else if (sp) begin
         m_act = 1'b0;
      end else if (a && m_act) begin
         if (m_last()) m_act = 1'b0;
         else          m_k++;
      end
      @(negedge clk);
      start = 1'b0; adv = 1'b0; stop = 1'b0;
      // change mode inputs to show they are not resampled (R2)
      bl_code = 3'($urandom); itl = 1'($urandom);
      check_all(tg);
   endtask

   task automatic go(input logic [COL_W-1:0] c, input logic [2:0] bc, input logic it,
                     input string tg);
      cyc(1'b1, c, bc, it, 1'b0, 1'b0, tg);
   endtask

   task automatic step(input string tg);
      cyc(1'b0, '0, 3'b000, 1'b0, 1'b1, 1'b0, tg);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk("R1", int'(col_vld), 0);
      chk("R1", int'(last), 0);
      chk("R1", int'(col_out), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: idle adv and stop do nothing
      cyc(1'b0, '0, 3'b000, 1'b0, 1'b1, 1'b1, "R11");
      cyc(1'b0, '0, 3'b000, 1'b0, 1'b1, 1'b0, "R11");

      // R4: sequential length 4 from 6 -> 6,7,4,5
      go(9'd6, 3'b010, 1'b0, "R2");
      chk("R2", int'(col_out), 6);
      repeat (3) step("R3");
      chk("R4", int'(col_out), 5);
      step("R7");

      // R5: interleaved length 8 from 0x1F5 -> ...5,4,7,6,1,0,3,2
      go(9'h1F5, 3'b011, 1'b1, "R2");
      step("R3");
      chk("R5", int'(col_out), 9'h1F4);
      cyc(1'b0, '0, 3'b000, 1'b0, 1'b0, 1'b0, "R3");
      cyc(1'b0, '0, 3'b000, 1'b0, 1'b0, 1'b0, "R3");
      repeat (6) step("R3");
      chk("R5", int'(col_out), 9'h1F2);
      step("R7");

      // R6: length 1 and reserved codes
      go(9'd77, 3'b000, 1'b0, "R6");
      chk("R6", int'(last), 1);
      step("R6");
      go(9'd78, 3'b101, 1'b1, "R6");
      chk("R6", int'(last), 1);
      step("R6");
      go(9'd79, 3'b001, 1'b0, "R6");
      chk("R6", int'(last), 0);
      step("R6");

      // R8: full page from 510 with itl set -> 510,511,0,1,...
      go(9'd510, 3'b111, 1'b1, "R8");
      repeat (2) step("R8");
      chk("R8", int'(col_out), 0);
      repeat (20) step("R8");
      // R9: stop with adv, stop wins
      cyc(1'b0, '0, 3'b000, 1'b0, 1'b1, 1'b1, "R9");

      // R10: restart mid burst, and start wins over stop
      go(9'd40, 3'b011, 1'b0, "R10");
      repeat (3) step("R10");
      cyc(1'b1, 9'd300, 3'b010, 1'b1, 1'b1, 1'b1, "R10");
      chk("R10", int'(col_out), 300);
      repeat (3) step("R10");

      // random bursts
      for (int n = 0; n < 400; n++) begin
         logic [2:0] codes [6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b111, 3'b110};
         go(COL_W'($urandom), codes[$urandom_range(0, 5)], 1'($urandom), "R2");
         for (int t = 0; t < 14; t++) begin
            int r = $urandom_range(0, 99);
            if (r < 3)       cyc(1'b1, COL_W'($urandom), 3'($urandom), 1'($urandom), 1'b1, 1'b0, "R10");
            else if (r < 6)  cyc(1'b0, '0, 3'b000, 1'b0, 1'($urandom), 1'b1, "R9");
            else if (r < 70) step("R3");
            else             cyc(1'b0, '0, 3'b000, 1'b0, 1'b0, 1'b0, "R3");
         end
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule